// File: doc/BRIEF.md
# Command-Driven Byte-Wide Flash Array

This block stands in for a byte-wide non-volatile memory that is driven through a single synchronous bus port. Each accepted bus write is decoded either as a command byte or as the second byte of a two-write sequence, which carries program data or an erase confirm. A sticky mode register decides what a read returns. A read can return an array byte, the status byte or one half of a 16-bit identifier.

Programming stores one byte per two-write sequence. Erasing clears a whole aligned block to 0xFF. The clearing is done by a sequencer that writes one byte per clock. While it runs, `busy` is high and `busReady` is low, and the bus master must hold its write until ready returns. Array and block sizes are power-of-two parameters. The array is a register file, so the defaults are kept small.

Top module: `bflash_top`

## Requirements
- R1: After reset the mode is array read, no two-write sequence is pending, `busy` is 0 and `busReady` is 1. A status read then returns 0x80.
- R2: First-write bytes 0xFF (array read), 0x70 (status read), 0x90 (identifier read) and 0xB0 (suspend/resume) each set only the mode. While the mode is 0xB0, reads return 0xFF.
- R3: First-write byte 0x50 sets status bits 5 and 4 to zero and puts the device in array-read mode at once.
- R4: First-write bytes 0x40 or 0x10 start a program sequence, and the address of that write is ignored. The next write stores its data byte at (address mod ARRAY_BYTES). The mode stays at the program code, so reads return 0xFF until another mode command is written.
- R5: After 0x20, a second write whose byte is not 0xD0 leaves the array unchanged. It sets status bit 5 (erase error) and bit 4 (byte-write error) and switches the mode to status read, so the status reads 0xB0.
- R6: After 0x20, a second write of 0xD0 sets every byte of the BLOCK_BYTES-aligned block holding the write address to 0xFF. `busy` is high for exactly BLOCK_BYTES cycles, and other blocks keep their contents.
- R7: While `busy` is high, `busReady` is low and any bus write is ignored.
- R8: The status byte is {~busy, 0, erase error, byte-write error, 0000}.
- R9: In identifier mode, an odd address returns DEV_ID[15:8] (default 0xA2) and an even address returns DEV_ID[7:0] (default 0x89).
- R10: A first-write byte that is not a known command leaves the mode, the status and the sequence state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | ADDR_W | Byte address for reads and writes |
| busWrEn | input | 1 | Write strobe, taken when busReady is high |
| busWrData | input | 8 | Command or data byte |
| busRdData | output | 8 | Read data, combinational from mode and address |
| busReady | output | 1 | Low while an erase is running |
| busy | output | 1 | Erase sequencer active |

## Verification
A corrupted mode register shows up on the very next read. The read returns 0xFF, status or identifier bytes where another kind of data was due. A lost or stuck second-write flag shows on the following write: a data byte is decoded as a command, or a command is stored into the array. That stored byte is only visible at the next array read of that address. A wrong erase counter shows as a `busy` pulse whose length differs from BLOCK_BYTES, or as bytes left unerased in, or erased outside of, the target block. The bench reads back edge and neighbouring bytes to expose both.

// File: rtl/bflash_pkg.sv
package bflash_pkg;
  localparam logic [7:0] CmdArray   = 8'hFF;
  localparam logic [7:0] CmdStatus  = 8'h70;
  localparam logic [7:0] CmdIdent   = 8'h90;
  localparam logic [7:0] CmdSusRes  = 8'hB0;
  localparam logic [7:0] CmdClear   = 8'h50;
  localparam logic [7:0] CmdProgA   = 8'h40;
  localparam logic [7:0] CmdProgB   = 8'h10;
  localparam logic [7:0] CmdEraseSu = 8'h20;
  localparam logic [7:0] CmdConfirm = 8'hD0;

  // strobes from control to datapath
  typedef struct packed {
    logic prog;
    logic eraseGo;
  } bflash_strb_t;
endpackage

// File: rtl/bflash_ctrl.sv
module bflash_ctrl
  import bflash_pkg::*;
#(
  parameter logic [15:0] DEV_ID = 16'hA289
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         wrEn,
  input  logic [7:0]   wrData,
  input  logic         addrLsb,
  input  logic         busy,
  input  logic [7:0]   arrayByte,
  output logic [7:0]   rdData,
  output bflash_strb_t strb
);
  logic [7:0] mode;
  logic       second;
  logic       errErase, errByte;
  logic       wrAcc;

  assign wrAcc = wrEn && !busy;

  function automatic logic isKnown(input logic [7:0] b);
    return (b == CmdArray) || (b == CmdStatus) || (b == CmdIdent) ||
           (b == CmdSusRes) || (b == CmdClear) || (b == CmdProgA) ||
           (b == CmdProgB) || (b == CmdEraseSu);
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mode     <= CmdArray;
      second   <= 1'b0;
      errErase <= 1'b0;
      errByte  <= 1'b0;
    end else if (wrAcc) begin
      if (!second) begin
        unique case (wrData)
          CmdArray, CmdStatus, CmdIdent, CmdSusRes: mode <= wrData;
          CmdClear: begin
            errErase <= 1'b0;
            errByte  <= 1'b0;
            mode     <= CmdArray;
          end
          CmdProgA, CmdProgB, CmdEraseSu: begin
            mode   <= wrData;
            second <= 1'b1;
          end
          default: ;
        endcase
      end else begin
        second <= 1'b0;
        if (mode == CmdEraseSu && wrData != CmdConfirm) begin
          mode     <= CmdStatus;
          errErase <= 1'b1;
          errByte  <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    strb.prog    = wrAcc && second && (mode == CmdProgA || mode == CmdProgB);
    strb.eraseGo = wrAcc && second && (mode == CmdEraseSu) && (wrData == CmdConfirm);
  end

  always_comb begin
    unique case (mode)
      CmdArray:  rdData = busy ? 8'hFF : arrayByte;
      CmdStatus: rdData = {~busy, 1'b0, errErase, errByte, 4'b0000};
      CmdIdent:  rdData = addrLsb ? DEV_ID[15:8] : DEV_ID[7:0];
      default:   rdData = 8'hFF;
    endcase
  end

  // writes during an erase must not disturb control state
  p_stall_r7: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && busy) |=> ($stable(mode) && $stable(second) && $stable(errErase)));

  p_bad_confirm_r5: assert property (@(posedge clk) disable iff (!rstN)
    (wrAcc && second && mode == CmdEraseSu && wrData != CmdConfirm)
      |=> (mode == CmdStatus && errErase && errByte && !second));

  p_clear_r3: assert property (@(posedge clk) disable iff (!rstN)
    (wrAcc && !second && wrData == CmdClear)
      |=> (!errErase && !errByte && mode == CmdArray));

  p_ignore_r10: assert property (@(posedge clk) disable iff (!rstN)
    (wrAcc && !second && !isKnown(wrData))
      |=> ($stable(mode) && $stable(errByte) && !second));
endmodule

// File: rtl/bflash_dpath.sv
module bflash_dpath
  import bflash_pkg::*;
#(
  parameter int ARRAY_BYTES = 1024,
  parameter int BLOCK_BYTES = 64
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  bflash_strb_t                   strb,
  input  logic [$clog2(ARRAY_BYTES)-1:0] addr,
  input  logic [7:0]                     wrData,
  output logic [7:0]                     arrayByte,
  output logic                           busy
);
  localparam int AW   = $clog2(ARRAY_BYTES);
  localparam int BW   = $clog2(BLOCK_BYTES);
  localparam int BLKW = AW - BW;
  localparam logic [BW-1:0] LastOff = BW'(BLOCK_BYTES - 1);

  logic [7:0]      mem [ARRAY_BYTES];
  logic [BLKW-1:0] blkIdx;
  logic [BW-1:0]   offCnt;

  // erase sequencer: one byte per clock
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy   <= 1'b0;
      blkIdx <= '0;
      offCnt <= '0;
    end else if (busy) begin
      offCnt <= offCnt + 1'b1;
      if (offCnt == LastOff) busy <= 1'b0;
    end else if (strb.eraseGo) begin
      busy   <= 1'b1;
      blkIdx <= addr[AW-1:BW];
      offCnt <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (busy) mem[{blkIdx, offCnt}] <= 8'hFF;
    else if (strb.prog) mem[addr] <= wrData;
  end

  assign arrayByte = mem[addr];

  p_erase_step_r6: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> (offCnt == $past(offCnt) + 1'b1));

  p_erase_start_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strb.eraseGo && !busy) |=> (busy && offCnt == '0));

  p_no_prog_busy_r7: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !strb.prog && !strb.eraseGo);
endmodule

// File: rtl/bflash_top.sv
module bflash_top
  import bflash_pkg::*;
#(
  parameter int          ARRAY_BYTES = 1024,
  parameter int          BLOCK_BYTES = 64,
  parameter int          ADDR_W      = 16,
  parameter logic [15:0] DEV_ID      = 16'hA289
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [7:0]        busWrData,
  output logic [7:0]        busRdData,
  output logic              busReady,
  output logic              busy
);
  localparam int AW = $clog2(ARRAY_BYTES);

  bflash_strb_t strb;
  logic [7:0]   arrayByte;
  logic         unusedHiAddr;

  // upper address bits wrap: array index is address modulo size
  assign unusedHiAddr = ^busAddr[ADDR_W-1:AW];
  assign busReady     = ~busy;

  bflash_ctrl #(.DEV_ID(DEV_ID)) ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .wrEn      (busWrEn),
    .wrData    (busWrData),
    .addrLsb   (busAddr[0]),
    .busy      (busy),
    .arrayByte (arrayByte),
    .rdData    (busRdData),
    .strb      (strb)
  );

  bflash_dpath #(.ARRAY_BYTES(ARRAY_BYTES), .BLOCK_BYTES(BLOCK_BYTES)) dpath_i (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .addr      (busAddr[AW-1:0]),
    .wrData    (busWrData),
    .arrayByte (arrayByte),
    .busy      (busy)
  );
endmodule

// File: tb/bflash_top_tb_top.sv
module bflash_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int BLK = 64;

  typedef struct {
    logic [15:0] addr;
    logic [7:0]  exp;
    string       tag;
  } rd_item_t;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] busAddr = '0;
  logic        busWrEn = 1'b0;
  logic [7:0]  busWrData = '0;
  logic [7:0]  busRdData;
  logic        busReady, busy;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  rd_item_t expQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  bflash_top #(.ARRAY_BYTES(1024), .BLOCK_BYTES(BLK), .ADDR_W(16), .DEV_ID(16'hA289)) dut_i (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(busRdData), .busReady(busReady), .busy(busy)
  );

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // driver: one accepted write
  task automatic busWrite(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    while (!busReady) @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  // driver: schedule a read and push its expected value
  task automatic expectRead(input logic [15:0] a, input logic [7:0] e, input string tag);
    rd_item_t it;
    @(negedge clk);
    busAddr = a;
    it.addr = a; it.exp = e; it.tag = tag;
    expQ.push_back(it);
  endtask

  // monitor: compare reads just after the falling edge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (expQ.size() > 0) begin
        rd_item_t it;
        it = expQ.pop_front();
        chk(busRdData == it.exp, it.tag, busRdData, it.exp);
      end
    end
  end

  task automatic runErase(input logic [15:0] a, input string tag);
    int n;
    busWrite(16'h0005, 8'h20);
    busWrite(a, 8'hD0);
    n = 0;
    while (busy && n < 1000) begin
      n++;
      @(negedge clk);
    end
    chk(n == BLK, tag, n, BLK);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    if (!finished) begin
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk); #1;
    // R1 reset state at the ports
    chk(busy == 1'b0, "R1", busy, 0);
    chk(busReady == 1'b1, "R1", busReady, 1);
    busWrite(16'h0000, 8'h70);
    expectRead(16'h0000, 8'h80, "R1 R8 status after reset");

    // R9 identifier bytes
    busWrite(16'h0123, 8'h90);
    expectRead(16'h0001, 8'hA2, "R9 odd");
    expectRead(16'h0002, 8'h89, "R9 even");
    expectRead(16'h0403, 8'hA2, "R9 odd high addr");

    // R6 erase blocks 0 and 1; R7 write ignored while busy
    busWrite(16'h0005, 8'h20);
    busWrite(16'h0023, 8'hD0);
    busAddr = 16'h0001; busWrData = 8'h90; busWrEn = 1'b1;
    n = 0;
    while (busy && n < 1000) begin
      #1;
      if (n == 0) chk(busReady == 1'b0, "R7 ready low", busReady, 0);
      n++;
      @(negedge clk);
      busWrEn = 1'b0;
    end
    busWrEn = 1'b0;
    chk(n == BLK, "R6 busy length", n, BLK);
    expectRead(16'h0001, 8'hFF, "R7 ident cmd dropped");
    runErase(16'h0064, "R6 busy length blk1");
    busWrite(16'h0000, 8'hFF);
    expectRead(16'h0000, 8'hFF, "R6 blk0 first");
    expectRead(16'h003F, 8'hFF, "R6 blk0 last");
    expectRead(16'h0040, 8'hFF, "R6 blk1 first");

    // R4 program with both codes
    busWrite(16'h03E7, 8'h40);
    busWrite(16'h000A, 8'h5A);
    expectRead(16'h000A, 8'hFF, "R4 mode still program");
    busWrite(16'h0000, 8'hFF);
    expectRead(16'h000A, 8'h5A, "R4 byte stored");
    expectRead(16'h000B, 8'hFF, "R4 neighbour untouched");
    busWrite(16'h0000, 8'h10);
    busWrite(16'h0446, 8'h3C);   // 0x446 mod 1024 = 0x46
    busWrite(16'h0000, 8'hFF);
    expectRead(16'h0046, 8'h3C, "R4 modulo address");

    // R6 erase of block 1 spares block 0
    runErase(16'h007F, "R6 busy length blk1 again");
    busWrite(16'h0000, 8'hFF);
    expectRead(16'h0046, 8'hFF, "R6 erased byte");
    expectRead(16'h000A, 8'h5A, "R6 other block kept");

    // R10 unknown command bytes
    busWrite(16'h0000, 8'h33);
    expectRead(16'h000A, 8'h5A, "R10 array mode kept");
    busWrite(16'h0000, 8'h70);
    busWrite(16'h0000, 8'hD0);
    expectRead(16'h0000, 8'h80, "R10 status mode kept");

    // R5 bad erase confirm
    busWrite(16'h0000, 8'h20);
    busWrite(16'h000A, 8'h44);
    expectRead(16'h0000, 8'hB0, "R5 R8 error status");
    busWrite(16'h0000, 8'hFF);
    expectRead(16'h000A, 8'h5A, "R5 array unchanged");
    busWrite(16'h0000, 8'h70);
    expectRead(16'h0000, 8'hB0, "R5 errors sticky");

    // R3 status clear
    busWrite(16'h0000, 8'h50);
    expectRead(16'h000A, 8'h5A, "R3 back in array mode");
    busWrite(16'h0000, 8'h70);
    expectRead(16'h0000, 8'h80, "R3 status cleared");

    // R2 suspend/resume mode
    busWrite(16'h0000, 8'hB0);
    expectRead(16'h000A, 8'hFF, "R2 suspend mode reads FF");
    busWrite(16'h0000, 8'hFF);
    expectRead(16'h000A, 8'h5A, "R2 array read again");

    repeat (4) @(negedge clk);
    chk(expQ.size() == 0, "scoreboard drained", expQ.size(), 0);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule